// File: doc/BRIEF.md
# Multi-Line Receive Silo with Alarm Level

This block collects characters arriving from sixteen serial lines into one shared first-in first-out store. Each stored entry keeps the character, the number of the line it came from, and three error flags: parity, framing (the way a break shows up) and data overrun. Software takes entries out by reading a single status word. The top bit of that word marks a valid entry. Software keeps reading until a word comes back with that bit clear, which means the store is empty.

Each line has a one-character holding register. Characters that arrive on several lines in the same cycle are moved into the store one per cycle, lowest line number first.

A programmable alarm level decides when the receive interrupt request is raised. Level 0 asks for an interrupt as soon as any character is waiting. Levels 16 and 32 hold the request back until that many entries have built up. Writing 0 returns the block to per-character interrupts, which software does when it enables a line and after a bus reset.

Top module: `rx_silo`

## Requirements
- R1: After reset the store is empty, `rd_data` reads 0, `rx_irq` is low and the alarm level is 0.
- R2: A valid read word has this layout: bit 15 = 1 (valid), bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number (0 to 15), bits 7:0 = character.
- R3: Entries leave in the order they were stored. A character pulsed on `rx_valid` in the cycle before clock edge N is not visible before edge N+1, and it is visible at `rd_data` right after edge N+1 if the store was empty. A `rd_strobe` high at an edge removes the head entry.
- R4: When several lines hold characters in the same cycle, one character enters the store per cycle, starting with the lowest line number.
- R5: If a line receives a new character while its previous one is still waiting in the holding register, the old character is lost. The new one is stored with bit 14 (overrun) set.
- R6: A read strobe while the store is empty returns the word 0 and changes nothing: contents, occupancy and interrupt state are unchanged.
- R7: The store holds 64 entries. A character that reaches a full store at a clock edge is discarded, even if a read happens at the same edge. Bit 14 is then set on the most recently stored entry.
- R8: `alarm_wr` with data 0, 16 or 32 sets the alarm level to that value. Any other value is ignored and the level is unchanged.
- R9: With `irq_en` high, `rx_irq` is high when the level is 0 and at least one entry is waiting, or when the level is 16 or 32 and at least that many entries are waiting.
- R10: `rx_irq` drops as soon as the occupancy falls below the alarm level, or as soon as `irq_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 16 | One-cycle pulse per line: a character is ready |
| rx_data | input | 128 | Characters, 8 bits per line; line i sits at bits 8i+7:8i |
| rx_perr | input | 16 | Parity error for the character on each line |
| rx_ferr | input | 16 | Framing error (break) for the character on each line |
| rd_strobe | input | 1 | Pops the head entry shown on `rd_data` |
| alarm_wr | input | 1 | Writes the alarm level |
| alarm_wdata | input | 6 | Alarm level value (0, 16 or 32) |
| irq_en | input | 1 | Receive interrupt enable |
| rd_data | output | 16 | Head entry in the R2 layout, or 0 when empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is a per-line overrun. With one line active at a time, the holding register is drained into the store on the next edge, so the overrun path is never exercised. The stimulus therefore keeps line 0 pending on three consecutive cycles, so that the fixed priority starves line 5 while line 5 receives two characters back to back. The bench then expects the first line-5 character to be lost and the second one to come out last, with the overrun bit set. Filling all 64 slots and sending one more character checks the other overrun source, the mark placed on the newest stored entry.

// File: rtl/silo_pkg.sv
package silo_pkg;
  localparam int N_LINES = 16;
  localparam int LINE_W  = $clog2(N_LINES);
  localparam int CHAR_W  = 8;
  localparam int WORD_W  = 1 + 3 + LINE_W + CHAR_W;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] data;
  } silo_entry_t;
endpackage

// File: rtl/rx_line_capture.sv
module rx_line_capture
  import silo_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        rx_valid,
  input  logic [N_LINES*CHAR_W-1:0] rx_data,
  input  logic [N_LINES-1:0]        rx_perr,
  input  logic [N_LINES-1:0]        rx_ferr,
  input  logic [N_LINES-1:0]        grant,
  output logic [N_LINES-1:0]        pend,
  output silo_entry_t               ent [N_LINES]
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic        pend_q, pend_d;
    silo_entry_t ent_q, ent_d;

    // next state: a new arrival replaces a waiting one and marks overrun
    always_comb begin
      pend_d = pend_q;
      ent_d  = ent_q;
      if (rx_valid[i]) begin
        pend_d     = 1'b1;
        ent_d.data = rx_data[i*CHAR_W +: CHAR_W];
        ent_d.pe   = rx_perr[i];
        ent_d.fe   = rx_ferr[i];
        ent_d.line = LINE_W'(i);
        ent_d.ovr  = pend_q & ~grant[i];
      end else if (grant[i]) begin
        pend_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    // payload needs no reset: it is only read while pend_q is set
    always_ff @(posedge clk) begin
      if (rx_valid[i]) ent_q <= ent_d;
    end

    assign pend[i] = pend_q;
    assign ent[i]  = ent_q;
  end
endmodule

// File: rtl/rx_arbiter.sv
module rx_arbiter
  import silo_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] grant,
  output logic               grant_any,
  output logic [LINE_W-1:0]  grant_idx
);
  // lowest pending line wins
  assign grant     = pend & (~pend + N_LINES'(1));
  assign grant_any = |pend;

  always_comb begin
    grant_idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend[i]) grant_idx = LINE_W'(i);
    end
  end

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_any == (grant != '0)));
endmodule

// File: rtl/silo_fifo.sv
module silo_fifo
  import silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  silo_entry_t push_ent,
  input  logic        pop,
  output silo_entry_t head,
  output logic [CW-1:0] count,
  output logic        empty,
  output logic        full
);
  silo_entry_t   mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          accept, drop, do_pop;

  assign empty  = (count_q == '0);
  assign full   = (count_q == CW'(DEPTH));
  assign accept = push & ~full;
  assign drop   = push & full;
  assign do_pop = pop & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (accept) wr_ptr_d = wr_ptr_q + AW'(1);
    if (do_pop) rd_ptr_d = rd_ptr_q + AW'(1);
    case ({accept, do_pop})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage: write on accept, flag the newest entry on a drop
  always_ff @(posedge clk) begin
    if (accept)    mem[wr_ptr_q] <= push_ent;
    else if (drop) mem[wr_ptr_q - AW'(1)].ovr <= 1'b1;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
  // R3
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count_q == $past(count_q) + CW'(1)));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import silo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int ALARM_MID  = 16,
  parameter int ALARM_HIGH = 32,
  localparam int ALW = $clog2(ALARM_HIGH + 1),
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        rx_valid,
  input  logic [N_LINES*CHAR_W-1:0] rx_data,
  input  logic [N_LINES-1:0]        rx_perr,
  input  logic [N_LINES-1:0]        rx_ferr,
  input  logic                      rd_strobe,
  input  logic                      alarm_wr,
  input  logic [ALW-1:0]            alarm_wdata,
  input  logic                      irq_en,
  output logic [WORD_W-1:0]         rd_data,
  output logic                      rx_irq
);
  typedef enum logic [1:0] {ALM_EACH, ALM_MID, ALM_HIGH} alarm_e;

  logic [N_LINES-1:0] pend, grant;
  silo_entry_t        pend_ent [N_LINES];
  logic               grant_any;
  logic [LINE_W-1:0]  grant_idx;
  silo_entry_t        head;
  logic [CW-1:0]      count;
  logic               empty, full;
  alarm_e             alarm_q, alarm_d;
  logic [CW-1:0]      threshold;

  rx_line_capture u_capture (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .grant(grant),
    .pend(pend), .ent(pend_ent)
  );

  rx_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .grant(grant),
    .grant_any(grant_any), .grant_idx(grant_idx)
  );

  silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(grant_any), .push_ent(pend_ent[grant_idx]),
    .pop(rd_strobe), .head(head), .count(count), .empty(empty), .full(full)
  );

  // alarm level: only the three legal values are taken
  always_comb begin
    alarm_d = alarm_q;
    if (alarm_wr) begin
      if (alarm_wdata == '0)                alarm_d = ALM_EACH;
      else if (alarm_wdata == ALW'(ALARM_MID))  alarm_d = ALM_MID;
      else if (alarm_wdata == ALW'(ALARM_HIGH)) alarm_d = ALM_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= ALM_EACH;
    else        alarm_q <= alarm_d;
  end

  always_comb begin
    case (alarm_q)
      ALM_MID:  threshold = CW'(ALARM_MID);
      ALM_HIGH: threshold = CW'(ALARM_HIGH);
      default:  threshold = CW'(1);
    endcase
  end

  assign rx_irq  = irq_en & (count >= threshold);
  assign rd_data = empty ? '0 : {1'b1, head.ovr, head.fe, head.pe, head.line, head.data};

  // R8
  bad_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_wr && alarm_wdata != '0 && alarm_wdata != ALW'(ALARM_MID)
      && alarm_wdata != ALW'(ALARM_HIGH)) |=> $stable(alarm_q));
  // R6
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_data[WORD_W-1] && !grant_any) |=> (rd_data == '0));
endmodule

// File: tb/rx_silo_bench.sv
`timescale 1ns/1ps
module rx_silo_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  rx_valid, rx_perr, rx_ferr;
  logic [127:0] rx_data;
  logic         rd_strobe, alarm_wr, irq_en;
  logic [5:0]   alarm_wdata;
  logic [15:0]  rd_data;
  logic         rx_irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] mq[$];
  int lvl = 0;

  always #5 clk = ~clk;

  rx_silo u_rx_silo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rd_strobe(rd_strobe),
    .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata), .irq_en(irq_en),
    .rd_data(rd_data), .rx_irq(rx_irq)
  );

  function automatic logic [15:0] mkword(int ln, logic [7:0] d, logic pe, logic fe, logic ovr);
    return {1'b1, ovr, fe, pe, 4'(ln), d};
  endfunction

  function automatic logic exp_irq();
    if (!irq_en) return 1'b0;
    if (lvl == 0) return mq.size() >= 1;
    return mq.size() >= lvl;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_store(logic [15:0] w);
    if (mq.size() < 64) mq.push_back(w);
    else mq[mq.size()-1][14] = 1'b1;
  endtask

  task automatic send(int ln, logic [7:0] d, logic pe, logic fe);
    @(negedge clk);
    rx_valid[ln] = 1'b1; rx_data[ln*8 +: 8] = d; rx_perr[ln] = pe; rx_ferr[ln] = fe;
    @(negedge clk);
    rx_valid = '0; rx_perr = '0; rx_ferr = '0;
    @(negedge clk);
    model_store(mkword(ln, d, pe, fe, 1'b0));
  endtask

  task automatic rd_check(string req);
    logic [15:0] e;
    @(negedge clk);
    e = (mq.size() != 0) ? mq[0] : 16'h0;
    chk(req, rd_data, e);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
  endtask

  task automatic set_level(int v);
    @(negedge clk);
    alarm_wr = 1'b1; alarm_wdata = 6'(v);
    @(negedge clk);
    alarm_wr = 1'b0;
    if (v == 0 || v == 16 || v == 32) lvl = v;
  endtask

  task automatic irq_check(string req);
    chk(req, {15'b0, rx_irq}, {15'b0, exp_irq()});
  endtask

  task automatic drain(string req);
    while (mq.size() != 0) rd_check(req);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; rx_valid = '0; rx_perr = '0; rx_ferr = '0; rx_data = '0;
    rd_strobe = 1'b0; alarm_wr = 1'b0; alarm_wdata = '0; irq_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 irq", {15'b0, rx_irq}, 16'h0);
    send(2, 8'h41, 1'b0, 1'b0);
    chk("R1 level0 irq", {15'b0, rx_irq}, 16'h1);

    // R2 field layout with flags
    send(11, 8'hA5, 1'b1, 1'b0);
    send(6, 8'h00, 1'b0, 1'b1);
    drain("R2");

    // R3 latency and visibility
    @(negedge clk);
    rx_valid[7] = 1'b1; rx_data[7*8 +: 8] = 8'h77;
    @(negedge clk);
    rx_valid = '0;
    chk("R3 not yet visible", rd_data, 16'h0);
    @(negedge clk);
    chk("R3 visible", rd_data, mkword(7, 8'h77, 1'b0, 1'b0, 1'b0));
    mq.push_back(mkword(7, 8'h77, 1'b0, 1'b0, 1'b0));
    drain("R3");

    // R4 simultaneous arrivals leave lowest line first
    @(negedge clk);
    rx_valid = 16'h020A;
    rx_data[9*8 +: 8] = 8'h90; rx_data[3*8 +: 8] = 8'h30; rx_data[1*8 +: 8] = 8'h10;
    @(negedge clk);
    rx_valid = '0;
    repeat (4) @(negedge clk);
    mq.push_back(mkword(1, 8'h10, 1'b0, 1'b0, 1'b0));
    mq.push_back(mkword(3, 8'h30, 1'b0, 1'b0, 1'b0));
    mq.push_back(mkword(9, 8'h90, 1'b0, 1'b0, 1'b0));
    drain("R4");

    // R5 per-line overrun: line 0 starves line 5
    @(negedge clk);
    rx_valid = 16'h0021; rx_data[7:0] = 8'hA0; rx_data[5*8 +: 8] = 8'hB1;
    @(negedge clk);
    rx_valid = 16'h0021; rx_data[7:0] = 8'hA1; rx_data[5*8 +: 8] = 8'hB2;
    @(negedge clk);
    rx_valid = 16'h0001; rx_data[7:0] = 8'hA2;
    @(negedge clk);
    rx_valid = '0;
    repeat (6) @(negedge clk);
    mq.push_back(mkword(0, 8'hA0, 1'b0, 1'b0, 1'b0));
    mq.push_back(mkword(0, 8'hA1, 1'b0, 1'b0, 1'b0));
    mq.push_back(mkword(0, 8'hA2, 1'b0, 1'b0, 1'b0));
    mq.push_back(mkword(5, 8'hB2, 1'b0, 1'b0, 1'b1));
    drain("R5");

    // R6 empty read has no effect
    rd_check("R6 empty word");
    send(4, 8'h44, 1'b0, 1'b0);
    rd_check("R6 after empty read");
    rd_check("R6 empty again");
    irq_check("R6 irq");

    // R7 fill to 64 then overflow
    for (int k = 0; k < 64; k++) send(k % 16, 8'(k), 1'b0, 1'b0);
    send(12, 8'hEE, 1'b0, 1'b0);
    chk("R7 head kept", rd_data, mkword(0, 8'h00, 1'b0, 1'b0, 1'b0));
    drain("R7");
    rd_check("R7 empty after");

    // R8 R9 R10 alarm levels
    set_level(16);
    for (int k = 0; k < 15; k++) send(k, 8'h50 + 8'(k), 1'b0, 1'b0);
    irq_check("R9 below 16");
    send(15, 8'h5F, 1'b0, 1'b0);
    irq_check("R9 at 16");
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    irq_check("R10 enable low");
    irq_en = 1'b1;
    set_level(20);
    irq_check("R8 illegal ignored");
    rd_check("R10 read");
    irq_check("R10 below level");
    set_level(0);
    irq_check("R8 level0");
    set_level(32);
    irq_check("R8 level32");
    drain("R10");

    // random mix
    for (int s = 0; s < 400; s++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 5) send(int'($urandom % 16), 8'($urandom), 1'($urandom), 1'($urandom));
      else if (r < 8) rd_check("R3 random order");
      else if (r == 8) begin
        case ($urandom % 4)
          0: set_level(0);
          1: set_level(16);
          2: set_level(32);
          default: set_level(9);
        endcase
      end else begin
        @(negedge clk); irq_en = 1'($urandom);
        @(negedge clk);
      end
      irq_check("R9 random irq");
    end
    drain("R3 final");
    rd_check("R6 final empty");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule